// File: doc/BRIEF.md
# Multiplexed Grid and Dimming Timer for a Fluorescent Display

This block produces the time-multiplexed drive for a vacuum fluorescent display with two or three grids. It divides an oscillator clock into bit times, gives each grid a fixed slot of bit times in turn, and inside each slot opens a segment window and a grid on-time. Both lengths come from one 10-bit brightness code. During the window the segment lines carry the stored pattern for the current grid, and the active-low grid line of that grid is pulled low.

A strap input chooses between two-grid (1/2 duty) and three-grid (1/3 duty) operation. A dimming pulse and two sync pulses let a second driver follow the same timing: one sync pulse marks the start of each frame and the other marks the start of each slot. Serial loading of the brightness code and the three segment patterns is handled elsewhere; this block samples them at slot boundaries.

Top module: `vfd_grid_timer`

## Requirements
- R1: One bit time is 4 clock cycles and one grid slot is 1024 bit times (4096 clocks), so `sync_slot_o` rises every 4096 clocks.
- R2: With `duplex_i` high the grids take turns in the order 1, 2 (frame of 2048 bit times) and grid 3 stays inactive; with `duplex_i` low the order is 1, 2, 3 (frame of 3072 bit times).
- R3: Grid outputs are active low, at most one is active at a time, and the current grid is active exactly for the bit positions p within its slot with 3 <= p < code + 3.
- R4: A brightness code above 1016 behaves exactly like 1016, so the highest on-time is 1016 of 1024 bit times.
- R5: The segment window covers bit positions 0 <= p < code + 3 of each slot, and `dim_o` is high for exactly that window.
- R6: Segment line n (bit n of `seg_o`) is high only inside the window and only when bit n of the pattern for the current grid (`seg_g1_i`, `seg_g2_i` or `seg_g3_i`) is 1.
- R7: While reset is asserted all segment lines are low and all three grid lines are high.
- R8: `sync_frame_o` is high during bit position 0 of the grid 1 slot only; `sync_slot_o` is high during bit position 0 of every slot.
- R9: The brightness code and the segment pattern for a slot are taken at the slot's first clock; changes to the inputs during a slot have no effect until the next slot. The first slot after reset uses a code of 0 and a blank pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high |
| duplex_i | input | 1 | 1 selects two grids, 0 selects three grids |
| dim_code_i | input | 10 | Brightness code in bit times |
| seg_g1_i | input | 27 | Segment pattern for grid 1 |
| seg_g2_i | input | 27 | Segment pattern for grid 2 |
| seg_g3_i | input | 27 | Segment pattern for grid 3 |
| seg_o | output | 27 | Segment lines, active high |
| grid_n_o | output | 3 | Grid pre-driver lines, active low, bit 0 is grid 1 |
| dim_o | output | 1 | Dimming pulse, high during the segment window |
| sync_frame_o | output | 1 | Frame start pulse |
| sync_slot_o | output | 1 | Slot start pulse |

## Verification
The assertions take for granted that `duplex_i` is a strap that only changes while reset is held; a change mid-frame during the third slot could briefly light grid 3 in two-grid mode. The stimulus sets the strap before each reset release and never touches it afterwards. Brightness codes and patterns change only in the middle of a slot, well away from a boundary, and include the codes 0, 1, 1016, 1017 and 1023 alongside random values.

// File: rtl/vfd_grid_timer.sv
module vfd_grid_timer #(
  parameter int SEG_N       = 27,
  parameter int DIM_W       = 10,
  parameter int SLOT_BITS   = 1024,
  parameter int CLK_PER_BIT = 4,
  parameter int DIM_MAX     = 1016,
  parameter int SEG_LEAD    = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             duplex_i,
  input  logic [DIM_W-1:0] dim_code_i,
  input  logic [SEG_N-1:0] seg_g1_i,
  input  logic [SEG_N-1:0] seg_g2_i,
  input  logic [SEG_N-1:0] seg_g3_i,
  output logic [SEG_N-1:0] seg_o,
  output logic [2:0]       grid_n_o,
  output logic             dim_o,
  output logic             sync_frame_o,
  output logic             sync_slot_o
);

  localparam int DIV_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
  localparam int BIT_W = $clog2(SLOT_BITS);
  localparam int CMP_W = ((BIT_W > DIM_W) ? BIT_W : DIM_W) + 2;

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [1:0]       gidx_q;
  logic [DIM_W-1:0] code_q;
  logic [SEG_N-1:0] segs_q;

  logic             bit_end, slot_end, in_win, grid_on;
  logic [1:0]       last_g, next_g;
  logic [DIM_W-1:0] code_lim;
  logic [SEG_N-1:0] segs_next;

  assign bit_end  = (div_q == DIV_W'(CLK_PER_BIT - 1));
  assign slot_end = bit_end && (bit_q == BIT_W'(SLOT_BITS - 1));
  assign last_g   = duplex_i ? 2'd1 : 2'd2;
  assign next_g   = (gidx_q >= last_g) ? 2'd0 : gidx_q + 2'd1;
  assign code_lim = (dim_code_i > DIM_W'(DIM_MAX)) ? DIM_W'(DIM_MAX) : dim_code_i;

  always_comb begin
    case (next_g)
      2'd0:    segs_next = seg_g1_i;
      2'd1:    segs_next = seg_g2_i;
      default: segs_next = seg_g3_i;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q  <= '0;
      bit_q  <= '0;
      gidx_q <= '0;
      code_q <= '0;
      segs_q <= '0;
    end else begin
      div_q <= bit_end ? '0 : div_q + 1'b1;
      if (bit_end) bit_q <= slot_end ? '0 : bit_q + 1'b1;
      if (slot_end) begin
        gidx_q <= next_g;
        code_q <= code_lim;
        segs_q <= segs_next;
      end
    end
  end

  assign in_win  = CMP_W'(bit_q) < (CMP_W'(code_q) + CMP_W'(SEG_LEAD));
  assign grid_on = in_win && (CMP_W'(bit_q) >= CMP_W'(SEG_LEAD));

  assign seg_o        = in_win ? segs_q : '0;
  assign dim_o        = in_win;
  assign sync_slot_o  = (bit_q == '0);
  assign sync_frame_o = (bit_q == '0) && (gidx_q == 2'd0);

  for (genvar g = 0; g < 3; g++) begin : g_grid
    assign grid_n_o[g] = ~(grid_on && (gidx_q == 2'(g)));
  end

endmodule

// File: rtl/vfd_grid_timer_chk.sv
module vfd_grid_timer_chk #(
  parameter int SEG_N = 27
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             duplex_i,
  input logic [SEG_N-1:0] seg_o,
  input logic [2:0]       grid_n_o,
  input logic             dim_o,
  input logic             sync_frame_o,
  input logic             sync_slot_o
);

  assert_one_grid_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(~grid_n_o));

  assert_grid3_idle_duplex_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    duplex_i |-> grid_n_o[2]);

  assert_grid_inside_window_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (grid_n_o != 3'b111) |-> dim_o);

  assert_seg_dark_outside_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !dim_o |-> (seg_o == '0));

  assert_frame_on_slot_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    sync_frame_o |-> sync_slot_o);

  assert_seg_hold_midslot_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (dim_o && $past(dim_o) && !sync_slot_o && !$past(rst_i)) |-> $stable(seg_o));

endmodule

bind vfd_grid_timer vfd_grid_timer_chk #(.SEG_N(SEG_N)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .duplex_i(duplex_i), .seg_o(seg_o),
  .grid_n_o(grid_n_o), .dim_o(dim_o), .sync_frame_o(sync_frame_o),
  .sync_slot_o(sync_slot_o)
);

// File: tb/vfd_grid_timer_tb.sv
module vfd_grid_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_CLK   = 4096;

  logic        clk = 1'b0;
  logic        rst, duplex;
  logic [9:0]  dim_code;
  logic [26:0] seg_g1, seg_g2, seg_g3;
  logic [26:0] seg_o;
  logic [2:0]  grid_n;
  logic        dim_o, sync_frame, sync_slot;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  int slot_seq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfd_grid_timer dut_i (
    .clk_i(clk), .rst_i(rst), .duplex_i(duplex), .dim_code_i(dim_code),
    .seg_g1_i(seg_g1), .seg_g2_i(seg_g2), .seg_g3_i(seg_g3),
    .seg_o(seg_o), .grid_n_o(grid_n), .dim_o(dim_o),
    .sync_frame_o(sync_frame), .sync_slot_o(sync_slot)
  );

  function automatic int lim(input int c);
    return (c > 1016) ? 1016 : c;
  endfunction

  function automatic int pick_code(input int k);
    case (k)
      0: return 1016;
      1: return 1023;
      2: return 0;
      3: return 64;
      4: return 1017;
      5: return 1;
      default: return int'($urandom % 1024);
    endcase
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic new_inputs();
    dim_code = 10'(pick_code(slot_seq));
    seg_g1   = 27'($urandom);
    seg_g2   = 27'($urandom);
    seg_g3   = 27'($urandom);
    slot_seq++;
  endtask

  task automatic run_phase(input bit dup, input int nslots);
    int ng, t, cur_code, raw_code, b, s, g;
    logic [26:0] cur_segs, exp_seg;
    bit win, gon;
    logic [2:0] exp_grid;
    string tag;
    rst = 1'b1;
    duplex = dup;
    new_inputs();
    repeat (3) @(posedge clk);
    #1;
    check("R7", "reset segments", seg_o, 0);
    check("R7", "reset grids", grid_n, 3'b111);
    @(negedge clk);
    rst = 1'b0;
    ng = dup ? 2 : 3;
    cur_code = 0;
    raw_code = 0;
    cur_segs = '0;
    t = 0;
    while (t < nslots * SLOT_CLK && mismatched < 20) begin
      @(posedge clk);
      t++;
      s = t / SLOT_CLK;
      g = s % ng;
      if (t % SLOT_CLK == 0) begin
        raw_code = int'(dim_code);
        cur_code = lim(raw_code);
        cur_segs = (g == 0) ? seg_g1 : (g == 1) ? seg_g2 : seg_g3;
      end
      #1;
      b   = (t / 4) % 1024;
      win = b < cur_code + 3;
      gon = win && b >= 3;
      exp_seg  = win ? cur_segs : '0;
      exp_grid = ~(gon ? (3'b001 << g) : 3'b000);
      tag = (t % SLOT_CLK > 2000) ? "R9" : "R6";
      check(tag, "segments", seg_o, exp_seg);
      check("R3", "grids", grid_n, exp_grid);
      if (dup) check("R2", "grid3 idle", grid_n[2], 1);
      tag = (raw_code > 1016) ? "R4" : "R5";
      check(tag, "dim pulse", dim_o, win);
      check("R1", "slot sync", sync_slot, b == 0);
      check("R8", "frame sync", sync_frame, (b == 0) && (g == 0));
      if (t % SLOT_CLK == 2000) new_inputs();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    duplex = 1'b1;
    dim_code = '0;
    seg_g1 = '0;
    seg_g2 = '0;
    seg_g3 = '0;
    run_phase(1'b1, 8);
    run_phase(1'b0, 12);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 195000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule